// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block derives a steady one-microsecond tick from whatever oscillator clocks it, using a rational ratio rather than an integer divide. Software programs one 16-bit setting that names two byte values. The low byte holds the number of input clocks minus one. The high byte holds the number of microseconds those clocks span, minus one. A phase accumulator adds the microsecond count on every input clock. Each time the sum reaches the clock count, it wraps and emits one tick. The ticks drive a free-running 32-bit up-counter, and software reads that counter as a timestamp.

A small register port gives access to three words: the ratio setting, the counter and a freeze control. The port is a single-cycle write strobe with address and data. Reads are combinational on the address. The port accepts every access, so there is no back-pressure on this side. The block has no streaming data path. The tick is also brought out as a plain one-cycle pulse for local consumers.

Top module: `usec_prescaler`

## Requirements
- R1: After reset the counter reads 0, the freeze control reads 0 and the ratio setting reads its reset value 0x0000000B.
- R2: The ratio setting sits at byte offset 0x14. Bits 15:8 hold the microsecond count minus one and bits 7:0 hold the clock count minus one. A write stores wdata[15:0], and a read returns it with bits 31:16 at zero.
- R3: With freeze clear and a setting whose high byte is not above its low byte, N clock edges after a setting write advance the counter by exactly floor(N*(high+1)/(low+1)).
- R4: The clock edge that writes the ratio setting produces no tick and restarts the phase from zero, even when the value written is unchanged.
- R5: The counter reads at byte offset 0x10, is 32 bits wide and never advances by more than one per clock.
- R6: The freeze control is bit 0 at byte offset 0x4C. While it is 1, the counter and the phase both hold, and reads still return the held count. After it is cleared, counting resumes with the phase it had.
- R7: Writes to the counter address and to unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R8: Each of the settings 0x000B (12 MHz), 0x000C (13 MHz), 0x043F (12.8 MHz), 0x0453 (16.8 MHz), 0x045F (19.2 MHz), 0x04BF (38.4 MHz), 0x0019 (26 MHz) and 0x002F (48 MHz) yields 100 ticks in the clocks of 100 microseconds at its input rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| usec_tick | output | 1 | One-cycle pulse per microsecond tick |

## Verification
The phase-range property assumes that every programmed setting has a high byte no larger than its low byte. In other words, the ratio never asks for more than one tick per input clock. Every setting the stimulus writes obeys this, including the nominal rates and the extra ratios 4/6, 1/1 and 8/8. Writes to the counter and to unmapped addresses are made with freeze set, so a held count exposes any stray effect.

// File: rtl/usec_prescaler_pkg.sv
package usec_prescaler_pkg;
  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_RATIO  = 8'h14;
  localparam logic [7:0] OFS_FREEZE = 8'h4C;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_RATIO,
    SEL_FREEZE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    case (a)
      OFS_COUNT:  return SEL_COUNT;
      OFS_RATIO:  return SEL_RATIO;
      OFS_FREEZE: return SEL_FREEZE;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/usec_ratio_regs.sv
module usec_ratio_regs
  import usec_prescaler_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [2*FIELD_W-1:0] ratio_q,
  output logic                 freeze_q,
  output logic                 ratio_wr
);
  localparam int RATIO_W = 2 * FIELD_W;

  reg_sel_e sel;
  logic     freeze_wr;
  logic     unused_wdata_hi;

  assign sel             = decode_addr(bus_addr);
  assign ratio_wr        = bus_wr && (sel == SEL_RATIO);
  assign freeze_wr       = bus_wr && (sel == SEL_FREEZE);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:RATIO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= RATIO_RST;
      freeze_q <= 1'b0;
    end else begin
      if (ratio_wr)  ratio_q  <= bus_wdata[RATIO_W-1:0];
      if (freeze_wr) freeze_q <= bus_wdata[0];
    end
  end

  // R2: a ratio write lands exactly the low half of the data word
  assert_ratio_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> ratio_q == $past(bus_wdata[RATIO_W-1:0]));

  // R6: the freeze bit only changes through its own address
  assert_freeze_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_wr |=> $stable(freeze_q));
endmodule

// File: rtl/usec_phase_acc.sv
module usec_phase_acc #(
  parameter int FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*FIELD_W-1:0] ratio,
  input  logic                 restart,
  input  logic                 hold,
  output logic                 tick
);
  localparam int ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] limit;
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] sum;
  logic             wrap;

  assign step  = ACC_W'(ratio[2*FIELD_W-1:FIELD_W]) + ACC_W'(1);
  assign limit = ACC_W'(ratio[FIELD_W-1:0]) + ACC_W'(1);
  assign sum   = phase_q + step;
  assign wrap  = (sum >= limit);
  assign tick  = wrap && !hold && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (!hold)   phase_q <= wrap ? (sum - limit) : sum;
  end

  // R3: with step not above limit, the phase stays below the limit
  assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step <= limit) |-> (phase_q < limit));

  // R6: a held phase produces no tick and does not move
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (tick && !hold)   count <= count + CNT_W'(1);
  end

  // R5: the count never jumps by more than one
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

  // R6: frozen count holds
  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(count));
endmodule

// File: rtl/usec_prescaler.sv
module usec_prescaler
  import usec_prescaler_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              usec_tick
);
  localparam int RATIO_W = 2 * FIELD_W;

  logic [RATIO_W-1:0] ratio_q;
  logic               freeze_q;
  logic               ratio_wr;
  logic [CNT_W-1:0]   count;

  usec_ratio_regs #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .RATIO_RST(RATIO_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ratio_q(ratio_q), .freeze_q(freeze_q),
    .ratio_wr(ratio_wr)
  );

  usec_phase_acc #(.FIELD_W(FIELD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ratio(ratio_q), .restart(ratio_wr),
    .hold(freeze_q), .tick(usec_tick)
  );

  usec_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(usec_tick), .hold(freeze_q),
    .count(count)
  );

  always_comb begin
    case (decode_addr(bus_addr))
      SEL_COUNT:  bus_rdata = DATA_W'(count);
      SEL_RATIO:  bus_rdata = DATA_W'(ratio_q);
      SEL_FREEZE: bus_rdata = DATA_W'(freeze_q);
      default:    bus_rdata = '0;
    endcase
  end

  // R4: the edge that writes the ratio never advances the count
  assert_no_tick_on_ratio_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> $stable(count));

  // R7: unmapped reads are zero
  assert_unmapped_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_addr(bus_addr) == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_usec_prescaler.sv
module sim_usec_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [7:0] A_CNT = 8'h10, A_RAT = 8'h14, A_FRZ = 8'h4C, A_BAD = 8'h20;

  // {setting, clock edges, expected ticks}
  localparam logic [47:0] VEC [11] = '{
    {16'h000B, 16'd1200, 16'd100},
    {16'h000C, 16'd1300, 16'd100},
    {16'h043F, 16'd1280, 16'd100},
    {16'h0453, 16'd1680, 16'd100},
    {16'h045F, 16'd1920, 16'd100},
    {16'h04BF, 16'd3840, 16'd100},
    {16'h0019, 16'd2600, 16'd100},
    {16'h002F, 16'd4800, 16'd100},
    {16'h0305, 16'd10,   16'd6},
    {16'h0000, 16'd7,    16'd7},
    {16'h0707, 16'd5,    16'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        usec_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  usec_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .usec_tick(usec_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_CNT;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] c0, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_CNT, v); check("R1 count after reset", v, 32'd0);
    rd(A_RAT, v); check("R1 ratio after reset", v, 32'h0000000B);
    rd(A_FRZ, v); check("R1 freeze after reset", v, 32'd0);

    // R3 / R8: table of ratios
    for (int i = 0; i < 11; i++) begin
      rd(A_CNT, c0);
      wr(A_RAT, {16'h0000, VEC[i][47:32]});
      idle(int'(VEC[i][31:16]));
      rd(A_CNT, v);
      check($sformatf("R3 R8 ratio 0x%04h", VEC[i][47:32]), v - c0, 32'(VEC[i][15:0]));
    end

    // R2: upper data bits dropped on store
    wr(A_RAT, 32'hABCD_0305);
    rd(A_RAT, v); check("R2 ratio readback", v, 32'h0000_0305);

    // R4: rewriting the same value restarts the phase
    wr(A_RAT, 32'h0000_000B);
    rd(A_CNT, c0);
    idle(11);
    wr(A_RAT, 32'h0000_000B);
    rd(A_CNT, v); check("R4 no tick at write edge", v - c0, 32'd0);
    idle(11);
    rd(A_CNT, v); check("R4 phase restarted", v - c0, 32'd0);
    idle(1);
    rd(A_CNT, v); check("R4 tick after full period", v - c0, 32'd1);

    // R6: freeze holds count and phase
    rd(A_CNT, c0);
    wr(A_RAT, 32'h0000_000B);
    idle(30);
    wr(A_FRZ, 32'd1);
    idle(50);
    rd(A_CNT, v); check("R6 count held while frozen", v - c0, 32'd2);
    rd(A_FRZ, v); check("R6 freeze reads back", v, 32'd1);

    // R7: writes to counter and unmapped space ignored (while frozen)
    rd(A_CNT, c0);
    wr(A_CNT, 32'hFFFF_0000);
    rd(A_CNT, v); check("R7 counter write ignored", v, c0);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, v); check("R7 unmapped read zero", v, 32'd0);
    rd(A_RAT, v); check("R7 ratio untouched", v, 32'h0000_000B);
    rd(A_FRZ, v); check("R7 freeze untouched", v, 32'd1);

    wr(A_FRZ, 32'd0);
    idle(20);
    rd(A_CNT, v); check("R6 resume keeps phase", v - c0, 32'd2);

    // R5: fastest ratio advances by exactly one per clock
    wr(A_RAT, 32'h0000_0000);
    rd(A_CNT, c0);
    idle(1);
    rd(A_CNT, v); check("R5 single step", v - c0, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule